// File: doc/BRIEF.md
# Daisy-Chained Sample Readout Shifter

This block is the digital output path of a multi-input integrating converter. When a conversion finishes, a parallel load strobe delivers one sample word per input channel. The block captures them into a single serial register, pulls its active-low data-ready output low, and shifts the words out one bit per falling edge of an externally supplied data clock. The highest-numbered channel leaves first and the most significant bit of each word leads.

A serial input feeds the tail of the same register. Several devices can therefore be chained. Each device's serial output drives the serial input of the next device toward the host. After one device has sent its own words, the words of the devices behind it follow without a gap.

A format select picks full-width 20-bit words or 16-bit words. In 16-bit mode the four least significant bits of each sample are dropped. The format is captured at load time.

The data clock is slow and may stop between reads. It is brought into the system clock domain through a two-stage synchronizer, and its falling edges are detected there.

Top module: `readout_shifter`

## Requirements
- R1: After reset, `dvalid_n` is 1 and `ser_out` is 0.
- R2: One system clock after `load_stb` is sampled high, `dvalid_n` is 0 and `ser_out` shows the first bit of the new stream.
- R3: `dvalid_n` returns to 1 on the first synchronized data-clock fall after a load, that is, once `dclk` has been taken high and then low. It stays 0 while `dclk` is only high.
- R4: Each synchronized fall of `dclk` advances `ser_out` by exactly one bit. Within a word the most significant bit is sent first. Between falls the register holds.
- R5: Channel k (1-based) is taken from `load_words[k*20-1 -: 20]`. Words leave in descending channel order, from channel NCH down to channel 1.
- R6: With `fmt20`=1 each word is 20 bits. With `fmt20`=0 each word is bits [19:4] of the sample (16 bits), so the zero-input code 0x01000 is sent as 0x0100. The mode in force is the value of `fmt20` sampled with the load; later changes to `fmt20` have no effect until the next load.
- R7: `ser_in` is sampled on each synchronized `dclk` fall into the register tail. Once the local bits are exhausted, the upstream bits appear on `ser_out` in order. Two chained devices present 2·NCH words, ending with the far device's channel 1, and zeros after that.
- R8: A load while `dvalid_n` is still low, or while a read is part-way through, overwrites the register and restarts output at channel NCH, MSB.
- R9: `dclk` activity with no load pending leaves `dvalid_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_stb | input | 1 | One-cycle strobe: capture `load_words` |
| load_words | input | NCH*20 | Sample words, channel k at bits [k*20-1 -: 20] |
| fmt20 | input | 1 | 1: 20-bit words, 0: 16-bit words (sampled with the load) |
| dclk | input | 1 | Data clock, asynchronous, synchronized internally |
| ser_in | input | 1 | Serial input from the upstream device in the chain |
| ser_out | output | 1 | Serial data output |
| dvalid_n | output | 1 | Data ready, active low |

## Verification
The hardest situation to reach is the seam of a chain. Bits captured from `ser_in` must appear exactly one bit after the last local bit, and this must hold in both word widths, where the tail tap moves. The bench instantiates two devices in series, loads both with different data, and clocks out the full 2·NCH-word stream in each format. Every bit is compared against a queue-based model, so any slip at the seam shows up as a mismatch. A second hard case is a reload during a partial read, which is reached by stopping a read after a few bits and loading fresh data.

// File: rtl/readout_pkg.sv
package readout_pkg;
  // Bit index where the serial input enters in short-word mode.
  function automatic int short_tap(input int nch, input int wfull, input int wshort);
    return nch * (wfull - wshort);
  endfunction

  // Total register length in bits.
  function automatic int chain_len(input int nch, input int wfull);
    return nch * wfull;
  endfunction
endpackage

// File: rtl/rs_edge_sync.sv
module rs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_evt
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], async_in};
  end

  assign fall_evt = sync_q[STAGES] & ~sync_q[STAGES-1];

  // R4: a single dclk fall yields exactly one shift event
  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);
endmodule

// File: rtl/rs_packer.sv
module rs_packer #(
  parameter int NCH = 64,
  parameter int WF  = 20,
  parameter int WS  = 16
) (
  input  logic [NCH*WF-1:0] data_in,
  input  logic              fmt20,
  output logic [NCH*WF-1:0] packed_out
);
  localparam int LEN = readout_pkg::chain_len(NCH, WF);
  localparam int TAP = readout_pkg::short_tap(NCH, WF, WS);

  logic [LEN-1:0] short_vec;

  for (genvar i = 0; i < NCH; i++) begin : g_word
    // highest channel first, its top WS bits
    assign short_vec[LEN-1-i*WS -: WS] = data_in[(NCH-i)*WF-1 -: WS];
  end
  if (TAP > 0) begin : g_pad
    assign short_vec[TAP-1:0] = '0;
  end

  assign packed_out = fmt20 ? data_in : short_vec;
endmodule

// File: rtl/rs_shift_reg.sv
module rs_shift_reg #(
  parameter int NCH = 64,
  parameter int WF  = 20,
  parameter int WS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCH*WF-1:0] load_vec,
  input  logic              load_fmt20,
  input  logic              shift_evt,
  input  logic              ser_in,
  output logic              ser_out
);
  localparam int LEN = readout_pkg::chain_len(NCH, WF);
  localparam int TAP = readout_pkg::short_tap(NCH, WF, WS);

  logic [LEN-1:0] sreg;
  logic [LEN-1:0] sreg_nxt;
  logic           fmt_q;

  always_comb begin
    sreg_nxt = {sreg[LEN-2:0], 1'b0};
    if (fmt_q) sreg_nxt[0]   = ser_in;
    else       sreg_nxt[TAP] = ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      fmt_q <= 1'b1;
    end else if (load) begin
      sreg  <= load_vec;
      fmt_q <= load_fmt20;
    end else if (shift_evt) begin
      sreg  <= sreg_nxt;
    end
  end

  assign ser_out = sreg[LEN-1];

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_evt) |=> $stable(sreg));
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift_evt) |=> ser_out == $past(sreg[LEN-2]));
  assert_tail_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift_evt && fmt_q) |=> sreg[0] == $past(ser_in));
  assert_tail_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift_evt && !fmt_q) |=> sreg[TAP] == $past(ser_in));
endmodule

// File: rtl/rs_valid_flag.sv
module rs_valid_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fall_evt,
  output logic dvalid_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dvalid_n <= 1'b1;
    else if (load)     dvalid_n <= 1'b0;
    else if (fall_evt) dvalid_n <= 1'b1;
  end

  assert_load_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !dvalid_n);
  assert_clear_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && fall_evt) |=> dvalid_n);
  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid_n) |-> $past(fall_evt));
endmodule

// File: rtl/readout_shifter.sv
module readout_shifter #(
  parameter int NCH = 64,
  parameter int WF  = 20,
  parameter int WS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [NCH*WF-1:0] load_words,
  input  logic              fmt20,
  input  logic              dclk,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              dvalid_n
);
  logic              dclk_fall;
  logic [NCH*WF-1:0] packed_vec;

  rs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dclk), .fall_evt(dclk_fall));

  rs_packer #(.NCH(NCH), .WF(WF), .WS(WS)) u_pack (
    .data_in(load_words), .fmt20(fmt20), .packed_out(packed_vec));

  rs_shift_reg #(.NCH(NCH), .WF(WF), .WS(WS)) u_sreg (
    .clk(clk), .rst_n(rst_n), .load(load_stb), .load_vec(packed_vec),
    .load_fmt20(fmt20), .shift_evt(dclk_fall), .ser_in(ser_in),
    .ser_out(ser_out));

  rs_valid_flag u_valid (
    .clk(clk), .rst_n(rst_n), .load(load_stb), .fall_evt(dclk_fall),
    .dvalid_n(dvalid_n));

  // R9: without a load, dvalid_n can never go low
  assert_idle_stays_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_n && !load_stb) |=> dvalid_n);
endmodule

// File: tb/readout_shifter_tb.sv
module readout_shifter_tb;
  localparam int N = 64, W = 20, WS = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, load_stb = 1'b0, fmt20 = 1'b1, dclk = 1'b0;
  logic [N*W-1:0] flat_a = '0, flat_b = '0;
  logic ser_out, dvalid_n, ser_link, out_b, dvalid_b;

  int errors = 0, checks = 0;
  logic [W-1:0] wa [N];
  logic [W-1:0] wb [N];
  bit q[$];

  readout_shifter u_dut (.clk(clk), .rst_n(rst_n), .load_stb(load_stb),
    .load_words(flat_a), .fmt20(fmt20), .dclk(dclk), .ser_in(ser_link),
    .ser_out(ser_out), .dvalid_n(dvalid_n));
  readout_shifter u_next (.clk(clk), .rst_n(rst_n), .load_stb(load_stb),
    .load_words(flat_b), .fmt20(fmt20), .dclk(dclk), .ser_in(1'b0),
    .ser_out(out_b), .dvalid_n(dvalid_b));
  assign ser_link = out_b;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] gen(input int s, input int k);
    int v;
    v = k * 2654435 + s * 40503 + k * k * 97;
    return v[W-1:0];
  endfunction

  task automatic fill(input int s);
    for (int k = 0; k < N; k++) begin
      wa[k] = gen(s, k);
      wb[k] = gen(s + 7, k);
    end
    wa[0] = 20'h01000;     // zero-input code on channel 1 (R6)
    wa[N-1] = 20'hFFFFF;   // full scale on the highest channel
    for (int k = 0; k < N; k++) begin
      flat_a[k*W +: W] = wa[k];
      flat_b[k*W +: W] = wb[k];
    end
  endtask

  // expected stream: local words, then upstream words, highest channel first
  task automatic build_q(input bit full);
    int nb;
    logic [W-1:0] word;
    nb = full ? W : WS;
    q.delete();
    for (int d = 0; d < 2; d++)
      for (int ch = N - 1; ch >= 0; ch--) begin
        word = (d == 0) ? wa[ch] : wb[ch];
        for (int b = W - 1; b >= W - nb; b--) q.push_back(word[b]);
      end
  endtask

  function automatic logic exp_bit();
    return (q.size() > 0) ? q[0] : 1'b0;
  endfunction

  task automatic do_load(input string req);
    @(negedge clk) load_stb = 1'b1;
    @(negedge clk) load_stb = 1'b0;
    chk({req, " dvalid_n low after load"}, dvalid_n, 1'b0);
    chk({req, " first bit ch N MSB"}, ser_out, exp_bit());
  endtask

  task automatic dclk_cycle(input string req, input bit check_valid_high);
    dclk = 1'b1;
    repeat (4) @(negedge clk);
    if (check_valid_high) chk("R3 dvalid_n held while dclk high", dvalid_n, 1'b0);
    dclk = 1'b0;
    repeat (4) @(negedge clk);
    if (q.size() > 0) void'(q.pop_front());
    chk(req, ser_out, exp_bit());
  endtask

  task automatic read_all(input int local_bits, input int total, input string lreq);
    for (int i = 1; i < total; i++)
      dclk_cycle((i < local_bits) ? lreq : "R7 chained bit", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset dvalid_n", dvalid_n, 1'b1);
    chk("R1 reset ser_out", ser_out, 1'b0);

    // R9: data clock activity without a load
    dclk_cycle("R9 idle ser_out", 1'b0);
    chk("R9 dvalid_n stays high", dvalid_n, 1'b1);

    // 20-bit mode, two devices chained
    fmt20 = 1'b1; fill(1); build_q(1'b1);
    do_load("R2");
    dclk_cycle("R4 second bit", 1'b1);
    chk("R3 dvalid_n high after first fall", dvalid_n, 1'b1);
    read_all(N * W, 2 * N * W + 3, "R5 local bit");
    chk("R7 trailing zeros", ser_out, 1'b0);

    // 16-bit mode; format changed after the load must not matter
    fmt20 = 1'b0; fill(2); build_q(1'b0);
    do_load("R6");
    fmt20 = 1'b1;
    read_all(N * WS, 2 * N * WS + 3, "R6 short-word bit");
    chk("R3 dvalid_n high after 16-bit read", dvalid_n, 1'b1);

    // R8: reload during a partial read
    fmt20 = 1'b1; fill(3); build_q(1'b1);
    do_load("R8 first load");
    for (int i = 0; i < 10; i++) dclk_cycle("R8 partial read", 1'b0);
    fill(4); build_q(1'b1);
    do_load("R8 reload");
    for (int i = 0; i < 2 * W; i++) dclk_cycle("R8 bit after reload", 1'b0);

    // R8: reload while dvalid_n is still low
    fill(5); build_q(1'b1);
    do_load("R8 load A");
    fill(6); build_q(1'b1);
    do_load("R8 reload while valid low");
    for (int i = 0; i < W; i++) dclk_cycle("R8 bit after early reload", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule